// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with a late-late write. A command (operation, address and byte-lane enables) is captured on a rising clock edge. For a write, the data word is taken from the data input two enabled edges later. For a read, the word is presented two enabled edges later. Because both directions sit at the same pipeline depth, a host can issue reads and writes on consecutive edges in any mix without leaving idle cycles on the bus. A read issued straight after a write to the same word returns the newly written lanes.

Bursts of up to four words continue from a captured start address through an advance input. The burst keeps the operation and selection of its opening command, and it visits the four words of an aligned group in either linear or interleaved order. An active-low clock enable freezes the whole block for an edge. Three chip enables select the device for each command. A registered output carries a valid flag, and an output-enable input can blank it. When the flag is low, the data output is driven to zero, which is how the model shows high impedance.

Top module: `ntd_sram`

## Requirements
- R1: A command edge with rw_i=1 and the device selected is a read. After the second enabled edge that follows, rvalid_o is 1 and rdata_o holds the stored word at that address. A command edge with rw_i=0 is a write. Its data is sampled from wdata_i on the second enabled edge after the command.
- R2: Reads and writes may be issued on consecutive edges in any order. A read issued right after a write to the same address returns the written data. A read issued right before a write returns the old data.
- R3: bw_ni[i] is active low and gates byte lane i, which is bits 8i+7:8i. Lanes whose bit is 1 keep their old contents. With all bits 1, the write changes nothing.
- R4: With lbo_i=0 and adv_i=1, the next burst address is the start address with its two low bits replaced by (start[1:0] + count) mod 4, where count goes 1, 2, 3. The upper bits are unchanged.
- R5: With lbo_i=1, the burst's two low bits are start[1:0] XOR count.
- R6: On an enabled edge with adv_i=1, addr_i, rw_i and the three chip enables are ignored. The burst keeps the operation type and selection of the command that opened it.
- R7: On an edge with cen_ni=1, nothing changes: pipeline stages, the burst state, the memory, rdata_o and rvalid_o all hold. That edge does not count toward the two-edge latencies.
- R8: The device is selected only when ce_i=1, ce2_ni=0 and ce3_ni=0. A non-burst command edge without selection neither reads nor writes. Reads already in the pipeline still complete.
- R9: oe_ni=1 forces rvalid_o to 0 and rdata_o to 0. Writes proceed regardless of oe_ni.
- R10: During and right after reset, rvalid_o is 0 and rdata_o is 0.
- R11: Whenever rvalid_o is 0, rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; high stalls the edge |
| ce_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | Burst advance |
| rw_i | input | 1 | 1 read, 0 write |
| lbo_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| bw_ni | input | NB | Byte-lane write enables, active low |
| addr_i | input | AW | Word address |
| oe_ni | input | 1 | Output enable, active low |
| wdata_i | input | 8*NB | Write data, sampled two enabled edges after the command |
| rdata_o | output | 8*NB | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
Most internal faults in this block appear as a data word that is early, late or missing on rvalid_o and rdata_o. A stage register that fails to hold under a stall, or a lost selection bit, moves or removes the valid pulse. Such a fault shows at the ports on the third or fourth observed cycle after the command. A wrong burst offset or a mis-gated byte lane does not show when it happens. It stays hidden in the array until a later read of that address, so the bench reads back every word it writes, and it places burst data at distinct addresses so that linear and interleaved orders give different words.

// File: rtl/ntd_sram_pkg.sv
package ntd_sram_pkg;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;

  // two-bit offset inside an aligned group of four
  function automatic logic [1:0] burst_off(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/ntd_burst_ctrl.sv
module ntd_burst_ctrl
  import ntd_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          adv_i,
  input  logic          lbo_i,
  input  logic [AW-1:0] addr_i,
  input  op_e           op_i,
  input  logic          sel_i,
  output logic [AW-1:0] addr_o,
  output op_e           op_o,
  output logic          sel_o
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nx;
  op_e           op_q;
  logic          sel_q;

  assign cnt_nx = cnt_q + 2'd1;

  always_comb begin
    if (adv_i) begin
      addr_o = {base_q[AW-1:2], burst_off(base_q[1:0], cnt_nx, lbo_i)};
      op_o   = op_q;
      sel_o  = sel_q;
    end else begin
      addr_o = addr_i;
      op_o   = op_i;
      sel_o  = sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      op_q   <= OP_READ;
      sel_q  <= 1'b0;
    end else if (en_i) begin
      if (adv_i) begin
        cnt_q <= cnt_nx;
      end else begin
        base_q <= addr_i;
        cnt_q  <= '0;
        op_q   <= op_i;
        sel_q  <= sel_i;
      end
    end
  end

  assert_burst_keeps_cmd_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i) |=> ($stable(base_q) && $stable(op_q) && $stable(sel_q)));

  assert_burst_restart_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i) |=> (cnt_q == 2'd0));

endmodule

// File: rtl/ntd_sram_array.sv
module ntd_sram_array #(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [NB-1:0]   be_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NB*8-1:0] wdata_i,
  output logic [NB*8-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[b]) mem[addr_i] <= wdata_i[8*b +: 8];
    end

    assign rdata_o[8*b +: 8] = mem[addr_i];
  end

endmodule

// File: rtl/ntd_sram.sv
module ntd_sram
  import ntd_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cen_ni,
  input  logic            ce_i,
  input  logic            ce2_ni,
  input  logic            ce3_ni,
  input  logic            adv_i,
  input  logic            rw_i,
  input  logic            lbo_i,
  input  logic [NB-1:0]   bw_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            oe_ni,
  input  logic [NB*8-1:0] wdata_i,
  output logic [NB*8-1:0] rdata_o,
  output logic            rvalid_o
);

  localparam int DW = NB * 8;

  typedef struct packed {
    logic          vld;
    op_e           op;
    logic [AW-1:0] addr;
    logic [NB-1:0] ben;
  } stage_t;

  logic          en, sel_now;
  logic [AW-1:0] cmd_addr;
  op_e           cmd_op;
  logic          cmd_sel;
  stage_t        s1_q, s2_q;
  logic          rvalid_q;
  logic [DW-1:0] rdata_q, arr_rdata;
  logic          arr_we, s2_rd;

  assign en      = !cen_ni;
  assign sel_now = ce_i && !ce2_ni && !ce3_ni;

  ntd_burst_ctrl #(.AW(AW)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .adv_i  (adv_i),
    .lbo_i  (lbo_i),
    .addr_i (addr_i),
    .op_i   (op_e'(rw_i)),
    .sel_i  (sel_now),
    .addr_o (cmd_addr),
    .op_o   (cmd_op),
    .sel_o  (cmd_sel)
  );

  // write commit and read both happen at stage 2, so program order is kept
  assign s2_rd  = s2_q.vld && (s2_q.op == OP_READ);
  assign arr_we = en && s2_q.vld && (s2_q.op == OP_WRITE);

  ntd_sram_array #(.AW(AW), .NB(NB)) u_array (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .be_i    (s2_q.ben),
    .addr_i  (s2_q.addr),
    .wdata_i (wdata_i),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q     <= '0;
      s2_q     <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (en) begin
      s1_q.vld  <= cmd_sel;
      s1_q.op   <= cmd_op;
      s1_q.addr <= cmd_addr;
      s1_q.ben  <= ~bw_ni;
      s2_q      <= s1_q;
      rvalid_q  <= s2_rd;
      if (s2_rd) rdata_q <= arr_rdata;
    end
  end

  assign rvalid_o = rvalid_q && !oe_ni;
  assign rdata_o  = rvalid_o ? rdata_q : '0;

  assert_read_latency_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && s2_rd) |=> rvalid_q);

  assert_stall_hold_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(s1_q) && $stable(s2_q) && $stable(rvalid_q) && $stable(rdata_q)));

  assert_deselect_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !adv_i && !sel_now) |=> !s1_q.vld);

endmodule

// File: tb/ntd_sram_bench.sv
module ntd_sram_bench;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = NB * 8;
  localparam logic [DW-1:0] GARB = 32'hDEAD_BEEF;

  logic clk_i = 1'b0, rst_ni = 1'b0, cen_ni = 1'b0;
  logic ce_i = 1'b0, ce2_ni = 1'b1, ce3_ni = 1'b1;
  logic adv_i = 1'b0, rw_i = 1'b1, lbo_i = 1'b0, oe_ni = 1'b0;
  logic [NB-1:0] bw_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #5 clk_i = ~clk_i;

  ntd_sram #(.AW(AW), .NB(NB)) u_ntd_sram (
    .clk_i, .rst_ni, .cen_ni, .ce_i, .ce2_ni, .ce3_ni, .adv_i, .rw_i, .lbo_i,
    .bw_ni, .addr_i, .oe_ni, .wdata_i, .rdata_o, .rvalid_o
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] bw);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (!bw[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic logic [AW-1:0] bseq(input logic [AW-1:0] st, input int k, input logic ilv);
    logic [1:0] c = 2'(k);
    return {st[AW-1:2], ilv ? (st[1:0] ^ c) : (st[1:0] + c)};
  endfunction

  // observe outputs of earlier edges, then drive inputs for the next edge
  // ds: 0 selected, 1 ce_i off, 2 ce2_ni off, 3 ce3_ni off
  task automatic slot(input logic rw, input logic [AW-1:0] a, input logic [NB-1:0] bw,
                      input logic adv, input int ds, input logic cen, input logic oe,
                      input logic [DW-1:0] wd, input logic ev, input logic [DW-1:0] ed,
                      input string tag);
    @(negedge clk_i);
    check({tag, " valid"}, DW'(rvalid_o), DW'(ev));
    check(ev ? {tag, " data"} : {tag, " R11 zero"}, rdata_o, ev ? ed : '0);
    rw_i = rw; addr_i = a; bw_ni = bw; adv_i = adv; cen_ni = cen; oe_ni = oe; wdata_i = wd;
    ce_i = (ds != 1); ce2_ni = (ds == 2); ce3_ni = (ds == 3);
  endtask

  task automatic nop(input logic [DW-1:0] wd, input logic ev, input logic [DW-1:0] ed,
                     input string tag);
    slot(1'b1, '0, '1, 1'b0, 1, 1'b0, 1'b0, wd, ev, ed, tag);
  endtask

  task automatic t_reset;
    #3;
    check("R10 valid in reset", DW'(rvalid_o), '0);
    check("R10 data in reset", rdata_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    nop(GARB, 1'b0, '0, "R10 after reset");
    nop(GARB, 1'b0, '0, "R10 after reset");
  endtask

  task automatic t_mixed;
    ref_mem[10] = 32'hA0A0_0010;
    ref_mem[11] = 32'hB0B0_0011;
    slot(1'b0, 8'd10, '0, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R2");
    slot(1'b1, 8'd10, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R2");
    slot(1'b0, 8'd11, '0, 1'b0, 0, 1'b0, 1'b0, ref_mem[10], 1'b0, '0, "R2");
    slot(1'b1, 8'd11, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R2");
    nop(ref_mem[11], 1'b1, ref_mem[10], "R1 read after write");
    nop(GARB, 1'b0, '0, "R2 write slot");
    nop(GARB, 1'b1, ref_mem[11], "R2 read after write");
    nop(GARB, 1'b0, '0, "R2 idle");
    // read then write, same word
    slot(1'b1, 8'd11, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R2");
    slot(1'b0, 8'd11, '0, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R2");
    nop(GARB, 1'b0, '0, "R2");
    nop(32'hC0C0_0011, 1'b1, ref_mem[11], "R2 read before write old data");
    ref_mem[11] = 32'hC0C0_0011;
    nop(GARB, 1'b0, '0, "R2");
  endtask

  task automatic t_bytes;
    logic [DW-1:0] exp;
    exp = merge(32'h1122_3344, 32'hAABB_CCDD, 4'b1010);
    slot(1'b0, 8'd20, 4'b0000, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R3");
    slot(1'b0, 8'd20, 4'b1010, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R3");
    slot(1'b1, 8'd20, 4'b1111, 1'b0, 0, 1'b0, 1'b0, 32'h1122_3344, 1'b0, '0, "R3");
    slot(1'b0, 8'd20, 4'b1111, 1'b0, 0, 1'b0, 1'b0, 32'hAABB_CCDD, 1'b0, '0, "R3");
    slot(1'b1, 8'd20, 4'b1111, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R3");
    nop(32'h5555_5555, 1'b1, exp, "R3 lanes 0 and 2 only");
    nop(GARB, 1'b0, '0, "R3");
    nop(GARB, 1'b1, exp, "R3 all lanes disabled");
    nop(GARB, 1'b0, '0, "R3");
    ref_mem[20] = exp;
  endtask

  task automatic t_burst;
    // linear write burst from 0x32; pin-side read and deselect during advance must be ignored
    lbo_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] wd = (k >= 2) ? (32'hB000_0000 + DW'(k - 2)) : GARB;
      if (k == 0) slot(1'b0, 8'h32, '0, 1'b0, 0, 1'b0, 1'b0, wd, 1'b0, '0, "R6 write burst");
      else if (k <= 3) slot(1'b1, 8'hFF, '0, 1'b1, 1, 1'b0, 1'b0, wd, 1'b0, '0, "R6 write burst");
      else nop(wd, 1'b0, '0, "R4 write burst");
      if (k < 4) ref_mem[bseq(8'h32, k, 1'b0)] = 32'hB000_0000 + DW'(k);
    end
    // interleaved read burst from 0x31
    lbo_i = 1'b1;
    for (int k = 0; k < 7; k++) begin
      logic ev = (k >= 3);
      logic [DW-1:0] ed = ev ? ref_mem[bseq(8'h31, k - 3, 1'b1)] : '0;
      if (k == 0) slot(1'b1, 8'h31, '1, 1'b0, 0, 1'b0, 1'b0, GARB, ev, ed, "R5 interleaved");
      else if (k <= 3) slot(1'b0, 8'h00, '0, 1'b1, 3, 1'b0, 1'b0, GARB, ev, ed, "R5 R6 interleaved");
      else nop(GARB, ev, ed, "R5 interleaved");
    end
    // linear read burst from 0x33
    lbo_i = 1'b0;
    for (int k = 0; k < 7; k++) begin
      logic ev = (k >= 3);
      logic [DW-1:0] ed = ev ? ref_mem[bseq(8'h33, k - 3, 1'b0)] : '0;
      if (k == 0) slot(1'b1, 8'h33, '1, 1'b0, 0, 1'b0, 1'b0, GARB, ev, ed, "R4 linear");
      else if (k <= 3) slot(1'b0, 8'h10, '0, 1'b1, 2, 1'b0, 1'b0, GARB, ev, ed, "R4 R6 linear");
      else nop(GARB, ev, ed, "R4 linear");
    end
  endtask

  task automatic t_stall;
    // write with a stalled edge between command and data
    slot(1'b0, 8'd40, '0, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R7");
    slot(1'b1, 8'd41, '0, 1'b0, 0, 1'b1, 1'b0, 32'h0BAD_0BAD, 1'b0, '0, "R7");
    nop(GARB, 1'b0, '0, "R7");
    nop(32'h7777_0040, 1'b0, '0, "R7");
    ref_mem[40] = 32'h7777_0040;
    // read with two stalled edges
    slot(1'b1, 8'd40, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R7");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b1, 1'b0, GARB, 1'b0, '0, "R7");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b1, 1'b0, GARB, 1'b0, '0, "R7");
    nop(GARB, 1'b0, '0, "R7 stalled edges do not count");
    nop(GARB, 1'b0, '0, "R7 stalled edges do not count");
    nop(GARB, 1'b1, ref_mem[40], "R7 stalled read");
    // output holds across stalls
    slot(1'b1, 8'd10, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R7");
    nop(GARB, 1'b0, '0, "R7");
    nop(GARB, 1'b0, '0, "R7");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b1, 1'b0, GARB, 1'b1, ref_mem[10], "R7");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b1, 1'b0, GARB, 1'b1, ref_mem[10], "R7 hold");
    nop(GARB, 1'b1, ref_mem[10], "R7 hold");
    nop(GARB, 1'b0, '0, "R7 after hold");
  endtask

  task automatic t_desel;
    slot(1'b1, 8'd10, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R8");
    slot(1'b1, 8'd11, '1, 1'b0, 2, 1'b0, 1'b0, GARB, 1'b0, '0, "R8");
    slot(1'b0, 8'd10, '0, 1'b0, 3, 1'b0, 1'b0, GARB, 1'b0, '0, "R8");
    slot(1'b1, 8'd10, '1, 1'b0, 1, 1'b0, 1'b0, GARB, 1'b1, ref_mem[10], "R8 pending read completes");
    nop(32'h0BAD_0010, 1'b0, '0, "R8 ce2 off read");
    slot(1'b1, 8'd10, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R8 ce3 off write");
    nop(GARB, 1'b0, '0, "R8 ce off read");
    nop(GARB, 1'b0, '0, "R8");
    nop(GARB, 1'b1, ref_mem[10], "R8 deselected write ignored");
  endtask

  task automatic t_oe;
    slot(1'b1, 8'd11, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R9");
    nop(GARB, 1'b0, '0, "R9");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b0, 1'b1, GARB, 1'b0, '0, "R9");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b0, 1'b0, GARB, 1'b0, '0, "R9 oe high blanks");
    // writes while oe_ni is high
    slot(1'b0, 8'd50, '0, 1'b0, 0, 1'b0, 1'b1, GARB, 1'b0, '0, "R9");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b0, 1'b1, GARB, 1'b0, '0, "R9");
    slot(1'b1, 8'd0, '1, 1'b0, 1, 1'b0, 1'b1, 32'h5050_5050, 1'b0, '0, "R9");
    ref_mem[50] = 32'h5050_5050;
    slot(1'b1, 8'd50, '1, 1'b0, 0, 1'b0, 1'b0, GARB, 1'b0, '0, "R9");
    nop(GARB, 1'b0, '0, "R9");
    nop(GARB, 1'b0, '0, "R9");
    nop(GARB, 1'b1, ref_mem[50], "R9 write with oe high");
    nop(GARB, 1'b0, '0, "R9");
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_mixed();
    t_bytes();
    t_burst();
    t_stall();
    t_desel();
    t_oe();
    finish_run();
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule